// File: doc/BRIEF.md
# Multiported Register File with Live Value Table

This block is the operand store of a four-slot wide-issue core. It holds 64 registers of 32 bits and serves four write ports and eight read ports in every cycle. Each of the four issue slots owns one write port and two read ports: operand a and operand b.

Storage is split into four replicated banks, one per write port. A bank takes writes only from its own port and feeds every read port. A small logic-built live value table keeps, for each register, the number of the write port that wrote it last. Each read port reads the addressed register from all four banks at once. Its table entry then picks the fresh copy. The banks themselves do not return data written in the same cycle, so a bypass stage after the selection substitutes the incoming write data whenever a write targets the address being read.

Reads are combinational from the address presented. Writes commit on the rising clock edge. Reset is synchronous and active low. It clears the live value table and leaves register contents as they are.

Top module: `lvt_regfile`

## Requirements
- R1: A write with its enable high commits on the rising clock edge. From the next cycle on, every read port that addresses that register returns the written value until another write to that register commits.
- R2: The eight read ports are independent and combinational. Read port 2*s+0 is operand a of slot s, and read port 2*s+1 is operand b of slot s. Each returns the value for its own address in the same cycle the address is presented.
- R3: Any write port may write any register. A later read returns the most recently written value, whichever of the four ports wrote it.
- R4: When an enabled write port targets the address a read port presents in the same cycle, that read port returns the incoming write data in that cycle, not the stored value.
- R5: When several enabled write ports target one register in the same cycle, the highest-numbered port wins. This holds both for the same-cycle forwarded value and for the value read back in later cycles.
- R6: While rst_n is low at a rising edge, all live value table entries return to write port 0. After reset, a register reads the value that write port 0 last stored to it. Writes presented while rst_n is low are neither stored nor forwarded.
- R7: A write port whose enable is low has no effect: no read port sees its address or data, neither in that cycle nor later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the live value table |
| wr_en | input | 4 | Write enable, one bit per write port |
| wr_addr | input | 4 x 6 | Write address, one field per write port |
| wr_data | input | 4 x 32 | Write data, one word per write port |
| rd_addr | input | 8 x 6 | Read address, one field per read port (2*slot + operand) |
| rd_data | output | 8 x 32 | Read data, one word per read port |

## Verification
A read result is due in the same cycle as its address, with no register on the path. The bench therefore drives every input just after the falling edge and compares all eight read ports one nanosecond later, well before the next rising edge. A write reaches storage at the next rising edge. The bench's array model is updated only after that edge, so a same-cycle hazard is expected through forwarding (R4, R5) and a stored value one cycle later (R1, R3). The reset rule (R6) is checked on the first cycle after rst_n rises. At that point the model has already dropped back to the values last written through port 0.

// File: rtl/lvtrf_pkg.sv
// Package: shared default dimensions of the multiported register file.
// Assumes: all modules take these only as parameter defaults.
package lvtrf_pkg;
    localparam int LVTRF_WIDTH  = 32;
    localparam int LVTRF_DEPTH  = 64;
    localparam int LVTRF_NUM_WR = 4;
    localparam int LVTRF_NUM_RD = 8;
endpackage

// File: rtl/lvtrf_bank.sv
// Module: one replicated storage bank.
// Holds DEPTH words written by a single write port and serves NUM_RD
// combinational reads. A read of the address being written in the same
// cycle returns the old content; forwarding is handled outside.
// Assumes: no reset of the contents.
module lvtrf_bank #(
    parameter int WIDTH  = lvtrf_pkg::LVTRF_WIDTH,
    parameter int DEPTH  = lvtrf_pkg::LVTRF_DEPTH,
    parameter int NUM_RD = lvtrf_pkg::LVTRF_NUM_RD,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [WIDTH-1:0]               wdata,
    input  logic [NUM_RD-1:0][AW-1:0]      raddr,
    output logic [NUM_RD-1:0][WIDTH-1:0]   rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the word of the owning write port on the rising edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One asynchronous read per consumer.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end
endmodule

// File: rtl/lvtrf_live_table.sv
// Module: live value table.
// For each register it records which write port wrote it last. When
// ports collide on one address, the highest-numbered port is recorded.
// Assumes: enables are already qualified by reset; built from flops.
module lvtrf_live_table #(
    parameter int DEPTH  = lvtrf_pkg::LVTRF_DEPTH,
    parameter int NUM_WR = lvtrf_pkg::LVTRF_NUM_WR,
    parameter int NUM_RD = lvtrf_pkg::LVTRF_NUM_RD,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_WR-1:0]          we,
    input  logic [NUM_WR-1:0][AW-1:0]  waddr,
    input  logic [NUM_RD-1:0][AW-1:0]  raddr,
    output logic [NUM_RD-1:0][PW-1:0]  rsel
);
    logic [PW-1:0] owner [DEPTH];

    // Clear to port 0 on reset; else record the writer, later ports overriding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                owner[a] <= '0;
            end
        end else begin
            for (int p = 0; p < NUM_WR; p++) begin
                if (we[p]) begin
                    owner[waddr[p]] <= PW'(p);
                end
            end
        end
    end

    // Combinational lookup for every read port.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rsel[r] = owner[raddr[r]];
    end
endmodule

// File: rtl/lvtrf_bypass.sv
// Module: output selection for one read port.
// Picks the live bank copy, then replaces it with same-cycle write data
// when any enabled write port hits the read address (highest port wins).
// Assumes: enables are already qualified by reset.
module lvtrf_bypass #(
    parameter int WIDTH  = lvtrf_pkg::LVTRF_WIDTH,
    parameter int DEPTH  = lvtrf_pkg::LVTRF_DEPTH,
    parameter int NUM_WR = lvtrf_pkg::LVTRF_NUM_WR,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
    input  logic [NUM_WR-1:0][WIDTH-1:0] bank_q,
    input  logic [PW-1:0]                sel,
    input  logic [AW-1:0]                raddr,
    input  logic [NUM_WR-1:0]            we,
    input  logic [NUM_WR-1:0][AW-1:0]    waddr,
    input  logic [NUM_WR-1:0][WIDTH-1:0] wdata,
    output logic [WIDTH-1:0]             q
);
    // Live copy first, then forwarding in rising port order.
    always_comb begin
        q = bank_q[sel];
        for (int p = 0; p < NUM_WR; p++) begin
            if (we[p] && (waddr[p] == raddr)) begin
                q = wdata[p];
            end
        end
    end
endmodule

// File: rtl/lvt_regfile.sv
// Module: multiported register file, NUM_WR writes and NUM_RD reads.
// One replicated bank per write port, a live value table choosing the
// fresh copy, and a bypass per read port for same-cycle writes.
// Assumes: read port 2*s+0/2*s+1 are operands a/b of slot s; writes
// are ignored while rst_n is low.
module lvt_regfile #(
    parameter int WIDTH  = lvtrf_pkg::LVTRF_WIDTH,
    parameter int DEPTH  = lvtrf_pkg::LVTRF_DEPTH,
    parameter int NUM_WR = lvtrf_pkg::LVTRF_NUM_WR,
    parameter int NUM_RD = lvtrf_pkg::LVTRF_NUM_RD,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WR-1:0]             wr_en,
    input  logic [NUM_WR-1:0][AW-1:0]     wr_addr,
    input  logic [NUM_WR-1:0][WIDTH-1:0]  wr_data,
    input  logic [NUM_RD-1:0][AW-1:0]     rd_addr,
    output logic [NUM_RD-1:0][WIDTH-1:0]  rd_data
);
    logic [NUM_WR-1:0]                        we_q;
    logic [NUM_WR-1:0][NUM_RD-1:0][WIDTH-1:0] bank_rd;
    logic [NUM_RD-1:0][NUM_WR-1:0][WIDTH-1:0] port_rd;
    logic [NUM_RD-1:0][PW-1:0]                live_sel;

    // Qualify every write with reset.
    assign we_q = wr_en & {NUM_WR{rst_n}};

    for (genvar w = 0; w < NUM_WR; w++) begin : g_bank
        lvtrf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_RD(NUM_RD)) u_bank (
            .clk   (clk),
            .we    (we_q[w]),
            .waddr (wr_addr[w]),
            .wdata (wr_data[w]),
            .raddr (rd_addr),
            .rdata (bank_rd[w])
        );
        for (genvar r = 0; r < NUM_RD; r++) begin : g_regroup
            assign port_rd[r][w] = bank_rd[w][r];
        end
    end

    lvtrf_live_table #(.DEPTH(DEPTH), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_q),
        .waddr (wr_addr),
        .raddr (rd_addr),
        .rsel  (live_sel)
    );

    for (genvar r = 0; r < NUM_RD; r++) begin : g_port
        lvtrf_bypass #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_WR(NUM_WR)) u_bypass (
            .bank_q (port_rd[r]),
            .sel    (live_sel[r]),
            .raddr  (rd_addr[r]),
            .we     (we_q),
            .waddr  (wr_addr),
            .wdata  (wr_data),
            .q      (rd_data[r])
        );
    end
endmodule

// File: rtl/lvt_regfile_checker.sv
// Module: temporal checks on the register file ports, bound to lvt_regfile.
// Assumes: default-sized parameters are passed through by the bind.
module lvt_regfile_checker #(
    parameter int WIDTH  = lvtrf_pkg::LVTRF_WIDTH,
    parameter int DEPTH  = lvtrf_pkg::LVTRF_DEPTH,
    parameter int NUM_WR = lvtrf_pkg::LVTRF_NUM_WR,
    parameter int NUM_RD = lvtrf_pkg::LVTRF_NUM_RD,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_WR-1:0]             wr_en,
    input logic [NUM_WR-1:0][AW-1:0]     wr_addr,
    input logic [NUM_WR-1:0][WIDTH-1:0]  wr_data,
    input logic [NUM_RD-1:0][AW-1:0]     rd_addr,
    input logic [NUM_RD-1:0][WIDTH-1:0]  rd_data
);
    localparam int TOP = NUM_WR - 1;

    for (genvar r = 0; r < NUM_RD; r++) begin : g_chk
        logic [NUM_WR-1:0] hit;
        // Which write ports target this read address now.
        always_comb begin
            for (int p = 0; p < NUM_WR; p++) begin
                hit[p] = wr_en[p] && (wr_addr[p] == rd_addr[r]);
            end
        end

        // R4: a lone hit from port 0 is forwarded in the same cycle.
        assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[0] && !(|hit[NUM_WR-1:1])) |-> (rd_data[r] == wr_data[0]));

        // R5: the highest port wins any same-cycle collision.
        assert_top_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hit[TOP] |-> (rd_data[r] == wr_data[TOP]));

        // R1: a committed write of the top port reads back on the next cycle.
        assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[TOP] |=> ((rd_addr[r] != $past(wr_addr[TOP])) || (|hit)
                            || (rd_data[r] == $past(wr_data[TOP]))));

        // R7: with no writes, a held address keeps its data.
        assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !(|$past(wr_en)) && !(|wr_en) && $stable(rd_addr[r]))
            |-> $stable(rd_data[r]));
    end
endmodule

bind lvt_regfile lvt_regfile_checker #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD)
) u_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/lvt_regfile_test.sv
`timescale 1ns/1ps
module lvt_regfile_test;
    localparam int NW = 4;
    localparam int NR = 8;
    localparam int D  = 64;
    localparam int AW = 6;
    localparam int W  = 32;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NW-1:0]         wr_en = '0;
    logic [NW-1:0][AW-1:0] wr_addr = '0;
    logic [NW-1:0][W-1:0]  wr_data = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR-1:0][W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] mem   [D];
    bit           known [D];
    logic [W-1:0] p0mem [D];
    bit           p0known [D];

    always #2.5 clk = ~clk;

    lvt_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int port, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s port %0d: actual %h expected %h", tag, port, got, exp);
        end
    endtask

    // Compare all read ports, then let one edge pass and update the model.
    task automatic step(input string tag);
        #1;
        for (int r = 0; r < NR; r++) begin
            logic [W-1:0] exp = '0;
            bit have = 1'b0;
            if (rst_n) begin
                for (int p = 0; p < NW; p++) begin
                    if (wr_en[p] && wr_addr[p] == rd_addr[r]) begin
                        exp = wr_data[p];
                        have = 1'b1;
                    end
                end
            end
            if (!have && known[rd_addr[r]]) begin
                exp = mem[rd_addr[r]];
                have = 1'b1;
            end
            if (have) check(tag, r, rd_data[r], exp);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int a = 0; a < D; a++) begin
                mem[a] = p0mem[a];
                known[a] = p0known[a];
            end
        end else begin
            for (int p = 0; p < NW; p++) begin
                if (wr_en[p]) begin
                    mem[wr_addr[p]] = wr_data[p];
                    known[wr_addr[p]] = 1'b1;
                    if (p == 0) begin
                        p0mem[wr_addr[p]] = wr_data[p];
                        p0known[wr_addr[p]] = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = '0;
    endtask

    task automatic all_read(input logic [AW-1:0] a);
        for (int r = 0; r < NR; r++) rd_addr[r] = a;
    endtask

    initial begin
        for (int a = 0; a < D; a++) begin
            known[a] = 1'b0;
            p0known[a] = 1'b0;
        end
        @(negedge clk);
        repeat (3) step("R6");
        rst_n = 1'b1;

        // R1/R3: eight registers written through all four ports.
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < NW; p++) begin
                wr_en[p] = 1'b1;
                wr_addr[p] = AW'(c * NW + p);
                wr_data[p] = 32'hA000_0000 + 32'(c * 16 + p);
            end
            step("R1");
        end
        idle();
        // R2: every read port on a different register in one cycle.
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(NR - 1 - r);
        step("R2");
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(r);
        step("R2");

        // R3: later write via another port takes over.
        wr_en[0] = 1'b1; wr_addr[0] = 6'd12; wr_data[0] = 32'h1111_0000;
        step("R3");
        idle(); wr_en[2] = 1'b1; wr_addr[2] = 6'd12; wr_data[2] = 32'h2222_0000;
        step("R3");
        idle(); all_read(6'd12);
        step("R3");

        // R4: same-cycle forward.
        wr_en[1] = 1'b1; wr_addr[1] = 6'd12; wr_data[1] = 32'h3333_0000;
        step("R4");
        idle();
        step("R4");

        // R5: all four ports on one register.
        all_read(6'd20);
        for (int p = 0; p < NW; p++) begin
            wr_en[p] = 1'b1; wr_addr[p] = 6'd20; wr_data[p] = 32'h5500_0000 + 32'(p);
        end
        step("R5");
        idle();
        step("R5");

        // R7: disabled ports carry address and data that must be ignored.
        for (int p = 0; p < NW; p++) begin
            wr_addr[p] = 6'd20; wr_data[p] = 32'hDEAD_0000 + 32'(p);
        end
        step("R7");
        step("R7");

        // R6: reset returns selection to port 0 and blocks writes.
        all_read(6'd30);
        wr_en[0] = 1'b1; wr_addr[0] = 6'd30; wr_data[0] = 32'h0000_AAAA;
        step("R6");
        idle(); wr_en[1] = 1'b1; wr_addr[1] = 6'd30; wr_data[1] = 32'h0000_BBBB;
        step("R6");
        idle();
        step("R6");
        rst_n = 1'b0;
        wr_en[0] = 1'b1; wr_addr[0] = 6'd30; wr_data[0] = 32'h0000_CCCC;
        step("R6");
        step("R6");
        idle(); rst_n = 1'b1;
        step("R6");

        // Random traffic with frequent hazards and collisions (R3, R4, R5).
        for (int i = 0; i < 3000; i++) begin
            bit narrow = ($urandom_range(0, 1) == 0);
            for (int p = 0; p < NW; p++) begin
                wr_en[p] = ($urandom_range(0, 2) != 0);
                wr_addr[p] = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, D - 1));
                wr_data[p] = $urandom;
            end
            for (int r = 0; r < NR; r++)
                rd_addr[r] = narrow ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, D - 1));
            step("R3");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule